// File: doc/BRIEF.md
# Dual-Bank Aperture Address Translator

This block turns a 17-bit offset into a host memory aperture into a linear address in a 2 MB video memory. Software programs two 8-bit bank registers. Their values are scaled by a selectable granularity, 4 KB or 16 KB, and added to the offset. When dual-bank mode is on, the upper half of the first 64 KB of the aperture uses its own bank, so two separate memory regions can be visible at the same time. In planar modes, a 2-bit map select chooses which part of the aperture is live. A write that falls outside that window is flagged for suppression; masking alone would let it wrap into the window. While the extensions are locked, the block does not translate: it marks the access for the standard path.

Each accepted strobe is captured, and the result appears on the registered outputs one cycle later. The outputs keep their values until the next strobe. The surrounding logic uses the address to steer the access and uses the drop flag to cancel the memory write.

Top module: `aperture_xlate`

## Requirements
- R1: While reset is held and until the first strobe after it, `res_valid`, `res_drop`, `res_bypass` and `res_addr` are all zero.
- R2: A strobe on `acc_valid` at a clock edge makes `res_valid` high after that edge. Without a strobe, `res_valid` goes low and the other outputs keep their values.
- R3: With `ext_lock` high, the result has `res_bypass`=1 and `res_drop`=0, and `res_addr` equals the host offset, zero-extended.
- R4: With `mode_dual`=1, an offset in 0x08000..0x0FFFF uses `bank_hi`. Every other offset, and every offset when `mode_dual`=0, uses `bank_lo`.
- R5: The bank base is bank×0x4000 when `mode_coarse`=1 and bank×0x1000 when it is 0.
- R6: Outside the narrow windows, the offset is masked to 0x7FFF when `mode_dual`=1 and to 0xFFFF when it is 0, and the mask is applied before the base is added. This applies to packed mode and to map select 1.
- R7: `res_addr` = (masked offset + base) modulo 0x200000.
- R8: Map select 0 (planar) uses the full 17-bit offset without masking and never drops.
- R9: Map select 1 (planar) drops writes whose offset has bit 16 set.
- R10: Map select 2 accepts only offsets with bits 16:15 = 2'b10, and map select 3 accepts only 2'b11. Both mask the offset to 0x7FFF, and a write outside the window is dropped.
- R11: A read (`acc_write`=0) is never dropped. It is still translated with the masking of its map select.
- R12: With `mode_packed`=1, the map select has no effect and nothing is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access strobe, one cycle per access |
| acc_write | input | 1 | 1 = write, 0 = read |
| host_off | input | 17 | Offset into the host aperture |
| ext_lock | input | 1 | Extensions locked: send the access to the standard path |
| mode_dual | input | 1 | Dual-bank mode enable |
| mode_coarse | input | 1 | 16 KB bank granularity (else 4 KB) |
| mode_packed | input | 1 | Packed-pixel mode (no window checks) |
| bank_lo | input | 8 | Bank 0 register |
| bank_hi | input | 8 | Bank 1 register |
| map_sel | input | 2 | Memory map select |
| res_valid | output | 1 | Result register updated this cycle |
| res_addr | output | 21 | Translated linear address |
| res_drop | output | 1 | Write lies outside the selected window |
| res_bypass | output | 1 | Access goes to the standard path |

## Verification
The assertions assume that the mode inputs, bank registers, map select, lock and offset are valid in every cycle that `acc_valid` is high. They also assume `acc_valid` stays low while reset is held. The bench drives every input on the falling clock edge, presents each access for exactly one rising edge, and reads results at the next falling edge. No strobe is given during reset or during the synchronizer release cycles. The hold check changes the inputs with the strobe low, to show that the result registers ignore them.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  typedef enum logic [1:0] {
    MAP_ALL   = 2'd0,
    MAP_LOW   = 2'd1,
    MAP_WIN_A = 2'd2,
    MAP_WIN_B = 2'd3
  } map_sel_e;
endpackage

// File: rtl/xlate_bank_base.sv
module xlate_bank_base #(
  parameter int OFF_W        = 17,
  parameter int BANK_W       = 8,
  parameter int ADDR_W       = 21,
  parameter int FINE_SHIFT   = 12,
  parameter int COARSE_SHIFT = 14
) (
  input  logic [OFF_W-1:0]  off,
  input  logic              dual,
  input  logic              coarse,
  input  logic [BANK_W-1:0] bank_lo,
  input  logic [BANK_W-1:0] bank_hi,
  output logic [ADDR_W-1:0] base
);
  localparam int HALF_BIT = OFF_W - 2;
  localparam int WIDE_W   = BANK_W + COARSE_SHIFT;

  logic              upper_half;
  logic [BANK_W-1:0] bank_pick;
  logic [WIDE_W-1:0] wide_base;

  // bank 1 region: top bit clear, half bit set
  always_comb begin
    upper_half = dual && !off[OFF_W-1] && off[HALF_BIT];
    bank_pick  = upper_half ? bank_hi : bank_lo;
    if (coarse)
      wide_base = WIDE_W'(bank_pick) << COARSE_SHIFT;
    else
      wide_base = WIDE_W'(bank_pick) << FINE_SHIFT;
  end

  generate
    if (WIDE_W >= ADDR_W) begin : g_trunc
      assign base = wide_base[ADDR_W-1:0];
    end else begin : g_ext
      assign base = ADDR_W'(wide_base);
    end
  endgenerate
endmodule

// File: rtl/xlate_window.sv
module xlate_window
  import xlate_pkg::*;
#(
  parameter int OFF_W = 17
) (
  input  logic [OFF_W-1:0] off,
  input  logic             write,
  input  logic             dual,
  input  logic             packed_mode,
  input  logic [1:0]       map_sel,
  output logic [OFF_W-1:0] eff_off,
  output logic             outside
);
  localparam int HALF_BIT = OFF_W - 2;
  localparam logic [OFF_W-1:0] HALF_MASK = OFF_W'((1 << HALF_BIT) - 1);
  localparam logic [OFF_W-1:0] FULL_MASK = OFF_W'((1 << (OFF_W - 1)) - 1);

  logic [OFF_W-1:0] wide_mask;
  logic [1:0]       top_bits;
  logic             miss;

  always_comb begin
    wide_mask = dual ? HALF_MASK : FULL_MASK;
    top_bits  = off[OFF_W-1:HALF_BIT];
    eff_off   = off;
    miss      = 1'b0;
    if (packed_mode) begin
      eff_off = off & wide_mask;
    end else begin
      unique case (map_sel_e'(map_sel))
        MAP_ALL:   eff_off = off;
        MAP_LOW: begin
          miss    = off[OFF_W-1];
          eff_off = off & wide_mask;
        end
        MAP_WIN_A: begin
          miss    = (top_bits != 2'b10);
          eff_off = off & HALF_MASK;
        end
        MAP_WIN_B: begin
          miss    = (top_bits != 2'b11);
          eff_off = off & HALF_MASK;
        end
        default:   eff_off = off;
      endcase
    end
    outside = write && miss;
  end
endmodule

// File: rtl/xlate_adder.sv
module xlate_adder #(
  parameter int OFF_W  = 17,
  parameter int ADDR_W = 21
) (
  input  logic [OFF_W-1:0]  eff_off,
  input  logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] sum
);
  // carry out of ADDR_W bits is discarded: wrap at memory size
  always_comb sum = ADDR_W'(eff_off) + base;
endmodule

// File: rtl/aperture_xlate.sv
module aperture_xlate #(
  parameter int OFF_W        = 17,
  parameter int BANK_W       = 8,
  parameter int ADDR_W       = 21,
  parameter int FINE_SHIFT   = 12,
  parameter int COARSE_SHIFT = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [OFF_W-1:0]  host_off,
  input  logic              ext_lock,
  input  logic              mode_dual,
  input  logic              mode_coarse,
  input  logic              mode_packed,
  input  logic [BANK_W-1:0] bank_lo,
  input  logic [BANK_W-1:0] bank_hi,
  input  logic [1:0]        map_sel,
  output logic              res_valid,
  output logic [ADDR_W-1:0] res_addr,
  output logic              res_drop,
  output logic              res_bypass
);
  logic [1:0]        rst_pipe;
  logic              rst_q;
  logic [ADDR_W-1:0] base;
  logic [OFF_W-1:0]  eff_off;
  logic              outside;
  logic [ADDR_W-1:0] sum;
  logic [ADDR_W-1:0] addr_d;
  logic              drop_d;
  logic              bypass_d;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  xlate_bank_base #(
    .OFF_W(OFF_W), .BANK_W(BANK_W), .ADDR_W(ADDR_W),
    .FINE_SHIFT(FINE_SHIFT), .COARSE_SHIFT(COARSE_SHIFT)
  ) u_base (
    .off(host_off), .dual(mode_dual), .coarse(mode_coarse),
    .bank_lo(bank_lo), .bank_hi(bank_hi), .base(base)
  );

  xlate_window #(.OFF_W(OFF_W)) u_win (
    .off(host_off), .write(acc_write), .dual(mode_dual),
    .packed_mode(mode_packed), .map_sel(map_sel),
    .eff_off(eff_off), .outside(outside)
  );

  xlate_adder #(.OFF_W(OFF_W), .ADDR_W(ADDR_W)) u_add (
    .eff_off(eff_off), .base(base), .sum(sum)
  );

  // next-state
  always_comb begin
    if (ext_lock) begin
      addr_d   = ADDR_W'(host_off);
      drop_d   = 1'b0;
      bypass_d = 1'b1;
    end else begin
      addr_d   = sum;
      drop_d   = outside;
      bypass_d = 1'b0;
    end
  end

  // registers, enabled by the strobe
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      res_valid  <= 1'b0;
      res_addr   <= '0;
      res_drop   <= 1'b0;
      res_bypass <= 1'b0;
    end else begin
      res_valid <= acc_valid;
      if (acc_valid) begin
        res_addr   <= addr_d;
        res_drop   <= drop_d;
        res_bypass <= bypass_d;
      end
    end
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_q)
    acc_valid |=> res_valid);
  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !acc_valid |=> (!res_valid && $stable(res_addr) && $stable(res_drop)));
  // R3
  lock_bypass_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (acc_valid && ext_lock) |=>
      (res_bypass && !res_drop && res_addr == ADDR_W'($past(host_off))));
  // R11
  read_keep_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (acc_valid && !acc_write) |=> !res_drop);
  // R12
  packed_keep_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (acc_valid && mode_packed) |=> !res_drop);
  // R3
  unlock_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (acc_valid && !ext_lock) |=> !res_bypass);
endmodule

// File: tb/test_aperture_xlate.sv
module test_aperture_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic [16:0] host_off = '0;
  logic        ext_lock = 1'b0;
  logic        mode_dual = 1'b0;
  logic        mode_coarse = 1'b0;
  logic        mode_packed = 1'b0;
  logic [7:0]  bank_lo = '0;
  logic [7:0]  bank_hi = '0;
  logic [1:0]  map_sel = '0;
  logic        res_valid;
  logic [20:0] res_addr;
  logic        res_drop;
  logic        res_bypass;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  aperture_xlate i_aperture_xlate (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .host_off(host_off), .ext_lock(ext_lock), .mode_dual(mode_dual),
    .mode_coarse(mode_coarse), .mode_packed(mode_packed),
    .bank_lo(bank_lo), .bank_hi(bank_hi), .map_sel(map_sel),
    .res_valid(res_valid), .res_addr(res_addr), .res_drop(res_drop),
    .res_bypass(res_bypass)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic setup(input logic dual, input logic coarse, input logic pk,
                       input logic [1:0] ms, input logic [7:0] b0, input logic [7:0] b1);
    mode_dual = dual; mode_coarse = coarse; mode_packed = pk;
    map_sel = ms; bank_lo = b0; bank_hi = b1; ext_lock = 1'b0;
  endtask

  // one access: drive at falling edge, captured at next rise, read at next fall
  task automatic access(input logic wr, input logic [16:0] off);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = wr; host_off = off;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic expect_res(input string req, input logic [20:0] a, input logic d);
    chk(req, {31'd0, res_valid}, 32'd1);
    chk(req, {11'd0, res_addr}, {11'd0, a});
    chk(req, {31'd0, res_drop}, {31'd0, d});
    chk(req, {31'd0, res_bypass}, 32'd0);
  endtask

  task automatic t_reset;
    // R1
    chk("R1", {31'd0, res_valid}, 32'd0);
    chk("R1", {11'd0, res_addr}, 32'd0);
    chk("R1", {30'd0, res_drop, res_bypass}, 32'd0);
  endtask

  task automatic t_banks;
    // R4 R6: dual, fine, packed; 0x9234 -> bank1(5): 0x5000 + 0x1234
    setup(1, 0, 1, 2'd0, 8'd2, 8'd5);
    access(1, 17'h09234);
    expect_res("R4", 21'h06234, 0);
    // R4: low half uses bank0
    access(1, 17'h01234);
    expect_res("R4", 21'h03234, 0);
    // R4 R6: dual off, 0x9234 -> bank0, mask 0xFFFF
    setup(0, 0, 1, 2'd0, 8'd2, 8'd5);
    access(1, 17'h09234);
    expect_res("R4", 21'h0B234, 0);
    // R6: bit 16 masked away in packed non-dual
    access(1, 17'h1ABCD);
    expect_res("R6", 21'h0CBCD, 0);
  endtask

  task automatic t_gran_wrap;
    // R5: coarse 0x03 -> 0xC000
    setup(0, 1, 1, 2'd0, 8'd3, 8'd0);
    access(0, 17'h00010);
    expect_res("R5", 21'h00C010, 0);
    // R7: 0x90*0x4000 = 0x240000, wraps at 2 MB
    setup(0, 1, 1, 2'd0, 8'h90, 8'd0);
    access(1, 17'h00010);
    expect_res("R7", 21'h040010, 0);
    // R7: offset plus base carries past 2 MB
    setup(0, 1, 1, 2'd0, 8'h7F, 8'd0);
    access(1, 17'h0FFFF);
    expect_res("R7", 21'h00BFFF, 0);
  endtask

  task automatic t_maps;
    // R8: map 0 full offset, no drop
    setup(0, 0, 0, 2'd0, 8'd1, 8'd3);
    access(1, 17'h1C000);
    expect_res("R8", 21'h1D000, 0);
    // R9: map 1 drops write with bit 16
    setup(0, 0, 0, 2'd1, 8'd1, 8'd3);
    access(1, 17'h10010);
    chk("R9", {31'd0, res_drop}, 32'd1);
    access(1, 17'h0F000);
    expect_res("R9", 21'h10000, 0);
    // R6 R9: map 1 dual, bank1 and 0x7FFF mask
    setup(1, 0, 0, 2'd1, 8'd1, 8'd3);
    access(1, 17'h09000);
    expect_res("R6", 21'h04000, 0);
    // R10: map 2 window 10
    setup(0, 0, 0, 2'd2, 8'd1, 8'd3);
    access(1, 17'h12345);
    expect_res("R10", 21'h03345, 0);
    access(1, 17'h1A000);
    chk("R10", {31'd0, res_drop}, 32'd1);
    // R11: read outside window kept, still masked
    access(0, 17'h1A000);
    expect_res("R11", 21'h03000, 0);
    // R10: map 3 window 11
    setup(0, 0, 0, 2'd3, 8'd1, 8'd3);
    access(1, 17'h1A000);
    expect_res("R10", 21'h03000, 0);
    access(1, 17'h12000);
    chk("R10", {31'd0, res_drop}, 32'd1);
    access(1, 17'h06000);
    chk("R10", {31'd0, res_drop}, 32'd1);
  endtask

  task automatic t_packed_ignores_map;
    // R12: packed with map 2, out-of-window write not dropped
    setup(0, 0, 1, 2'd2, 8'd1, 8'd3);
    access(1, 17'h1A000);
    expect_res("R12", 21'h0B000, 0);
    setup(0, 0, 1, 2'd3, 8'd1, 8'd3);
    access(1, 17'h00100);
    expect_res("R12", 21'h01100, 0);
  endtask

  task automatic t_lock;
    // R3
    setup(1, 1, 0, 2'd2, 8'h40, 8'h41);
    ext_lock = 1'b1;
    access(1, 17'h1ABCD);
    chk("R3", {31'd0, res_bypass}, 32'd1);
    chk("R3", {31'd0, res_drop}, 32'd0);
    chk("R3", {11'd0, res_addr}, 32'h0001ABCD);
    ext_lock = 1'b0;
  endtask

  task automatic t_hold;
    // R2: known result, then inputs change without strobe
    setup(0, 0, 1, 2'd0, 8'd2, 8'd0);
    access(1, 17'h00042);
    expect_res("R2", 21'h02042, 0);
    @(negedge clk);
    host_off = 17'h1FFFF; bank_lo = 8'hFF; ext_lock = 1'b1;
    mode_packed = 1'b0; map_sel = 2'd1; acc_write = 1'b1;
    @(negedge clk);
    chk("R2", {31'd0, res_valid}, 32'd0);
    chk("R2", {11'd0, res_addr}, 32'h00002042);
    chk("R2", {30'd0, res_drop, res_bypass}, 32'd0);
    ext_lock = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_banks();
    t_gran_wrap();
    t_maps();
    t_packed_ignores_map();
    t_lock();
    t_hold();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule